// File: doc/BRIEF.md
# Serial Audio Frame Capture

This block turns a serial audio stream into parallel PCM words, each tagged with the channel it belongs to. It accepts three wires: a word-select line, a bit clock and a data line. It handles both two-channel I2S framing and multi-channel TDM framing of up to eight slots. The slot length, the number of meaningful bits per sample and the TDM channel count come from configuration inputs. These inputs can express padded slots (sample shorter than the slot) and unpadded slots (sample fills the slot). Separate configuration bits invert the word-select polarity and choose which bit-clock edge captures data. An enable input gates capture.

All logic runs on the selected bit-clock edge. The result leaves the block as a one-cycle `out_valid` strobe together with `out_sample` and `out_channel`.

The controller is an enumerated machine with three states:
- `ST_OFF`: entered whenever the enable input is low.
- `ST_HUNT`: waiting for a frame marker.
- `ST_SLOT`: shifting in one slot.

It has these transitions:
- **OFF/HUNT → SLOT** on a sync edge.
- **SLOT → SLOT (next)** when a slot ends and another TDM channel follows.
- **SLOT → SLOT (resync)** on a sync edge inside a slot.
- **SLOT → HUNT** when a slot ends with nothing following.
- **any → OFF** when enable is low.

A sync edge is any word-select change in I2S mode, and only a rising effective word-select in TDM mode.

Top module: `aud_frame_cap`

## Requirements
- R1: After reset `out_valid` and `out_sample` are 0. The first active edge after reset only records the word-select level, so a word-select level held since reset never starts a slot.
- R2: In I2S mode (`cfg_tdm`=0), a falling effective word-select starts channel 0 (left) and a rising one starts channel 1 (right). The first data bit is taken on the active edge after the edge that first sees the new word-select level. Bits arrive MSB first.
- R3: A slot lasts `cfg_slot_bits` active edges. Only its first `cfg_depth` bits form the sample, which is right-aligned in `out_sample` with all higher bits 0. Padding bits are ignored whatever their value.
- R4: `out_valid` is high for exactly one cycle, the one following the active edge that takes the last bit of a slot. `out_sample` and `out_channel` are valid in that cycle.
- R5: In TDM mode (`cfg_tdm`=1), a rising effective word-select marks slot 0 (channel 0), and the channel number increases by one per slot up to `cfg_channels`-1. Slots beyond that, and falling word-select, are ignored until the next rising edge.
- R6: A sync edge seen before the last bit of the current slot discards the partial sample, with no output, and starts a new slot on that edge. A sync edge on the last-bit edge completes the old slot normally.
- R7: With `cfg_inv_ws`=1 the word-select input is inverted before any decoding.
- R8: With `cfg_inv_sck`=1 all capture and output updates happen on the falling bit-clock edge instead of the rising one.
- R9: While `cfg_enable` is low no sample is produced and any partial slot is dropped. Capture resumes at the next sync edge.
- R10: Samples of 32 bits (`cfg_depth`=32, `cfg_slot_bits`=32) are captured in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws | input | 1 | Word-select / frame marker |
| sd | input | 1 | Serial data, MSB first |
| cfg_enable | input | 1 | Capture enable |
| cfg_tdm | input | 1 | 0 = I2S stereo, 1 = TDM |
| cfg_slot_bits | input | 6 | Bit-clock periods per slot (2..32) |
| cfg_depth | input | 6 | Sample bits taken per slot (1..slot) |
| cfg_channels | input | 4 | TDM channels per frame (1..8) |
| cfg_inv_ws | input | 1 | Invert word-select |
| cfg_inv_sck | input | 1 | Capture on falling bit-clock edge |
| out_valid | output | 1 | One-cycle sample strobe |
| out_sample | output | 32 | Captured sample, right-aligned |
| out_channel | output | 3 | Channel index of the sample |

## Verification
The bench builds the block with its defaults: a 32-bit maximum slot, eight channels and a 32-bit sample register. These values bring the full 256-clock eight-slot TDM frame within reach, as well as the 144-clock unpadded six-slot frame and full-width 32-bit samples. For each captured word the bench checks the value, the channel, and the exact bit period in which the strobe appears. This covers padded and unpadded I2S, early word-select resynchronisation, extra TDM slots that must be skipped, both polarity inversions and enable gating.

// File: rtl/aud_cap_pkg.sv
package aud_cap_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HUNT = 2'd1,
        ST_SLOT = 2'd2
    } cap_state_t;
endpackage

// File: rtl/aud_cap_front.sv
module aud_cap_front (
    input  logic clk,
    input  logic rst_n,
    input  logic ws_raw,
    input  logic inv_ws,
    output logic ws_rise,
    output logic ws_fall
);
    logic ws_eff;
    logic ws_q;
    logic primed;

    assign ws_eff = ws_raw ^ inv_ws;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_q   <= 1'b0;
            primed <= 1'b0;
        end else begin
            ws_q   <= ws_eff;
            primed <= 1'b1;
        end
    end

    assign ws_rise = primed &  ws_eff & ~ws_q;
    assign ws_fall = primed & ~ws_eff &  ws_q;
endmodule

// File: rtl/aud_cap_ctrl.sv
module aud_cap_ctrl
    import aud_cap_pkg::*;
#(
    parameter  int SLOT_MAX   = 32,
    parameter  int CH_MAX     = 8,
    parameter  int SAMPLE_W   = 32,
    localparam int SLOT_CFG_W = $clog2(SLOT_MAX + 1),
    localparam int CNT_W      = $clog2(SLOT_MAX),
    localparam int CH_W       = $clog2(CH_MAX),
    localparam int CHN_W      = $clog2(CH_MAX + 1),
    localparam int DEPTH_W    = $clog2(SAMPLE_W + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  tdm,
    input  logic [SLOT_CFG_W-1:0] slot_bits,
    input  logic [DEPTH_W-1:0]    depth,
    input  logic [CHN_W-1:0]      channels,
    input  logic                  ws_rise,
    input  logic                  ws_fall,
    output logic                  clr,
    output logic                  shift_en,
    output logic                  emit,
    output logic                  out_valid,
    output logic [CH_W-1:0]       out_channel
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CH_W-1:0]  CH_ONE  = {{(CH_W-1){1'b0}}, 1'b1};

    cap_state_t      state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [CH_W-1:0]  chan, chan_n;
    logic             sync, last_bit, last_ch;
    logic [CH_W-1:0]  sync_ch;

    assign sync     = tdm ? ws_rise : (ws_rise | ws_fall);
    assign sync_ch  = (!tdm && ws_rise) ? CH_ONE : '0;
    assign last_bit = (int'(cnt) + 1) == int'(slot_bits);
    assign last_ch  = (int'(chan) + 1) >= int'(channels);
    assign shift_en = enable && (state == ST_SLOT) && (int'(cnt) < int'(depth));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            cnt   <= '0;
            chan  <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            chan  <= chan_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        chan_n  = chan;
        emit    = 1'b0;
        clr     = 1'b0;
        if (!enable) begin
            state_n = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF, ST_HUNT: begin
                    state_n = ST_HUNT;
                    if (sync) begin
                        state_n = ST_SLOT;
                        cnt_n   = '0;
                        chan_n  = sync_ch;
                        clr     = 1'b1;
                    end
                end
                ST_SLOT: begin
                    if (sync) begin
                        emit    = last_bit;
                        cnt_n   = '0;
                        chan_n  = sync_ch;
                        clr     = 1'b1;
                    end else if (last_bit) begin
                        emit = 1'b1;
                        if (tdm && !last_ch) begin
                            cnt_n  = '0;
                            chan_n = chan + CH_ONE;
                            clr    = 1'b1;
                        end else begin
                            state_n = ST_HUNT;
                        end
                    end else begin
                        cnt_n = cnt + CNT_ONE;
                    end
                end
                default: state_n = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_channel <= '0;
        end else begin
            out_valid <= emit;
            if (emit) out_channel <= chan;
        end
    end
endmodule

// File: rtl/aud_cap_shift.sv
module aud_cap_shift #(
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sd,
    input  logic                clr,
    input  logic                shift_en,
    input  logic                emit,
    output logic [SAMPLE_W-1:0] out_sample
);
    logic [SAMPLE_W-1:0] sh;
    logic [SAMPLE_W-1:0] sample_next;

    assign sample_next = shift_en ? {sh[SAMPLE_W-2:0], sd} : sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh         <= '0;
            out_sample <= '0;
        end else begin
            sh <= clr ? '0 : sample_next;
            if (emit) out_sample <= sample_next;
        end
    end
endmodule

// File: rtl/aud_frame_cap.sv
module aud_frame_cap #(
    parameter  int SLOT_MAX   = 32,
    parameter  int CH_MAX     = 8,
    parameter  int SAMPLE_W   = 32,
    localparam int SLOT_CFG_W = $clog2(SLOT_MAX + 1),
    localparam int CH_W       = $clog2(CH_MAX),
    localparam int CHN_W      = $clog2(CH_MAX + 1),
    localparam int DEPTH_W    = $clog2(SAMPLE_W + 1)
) (
    input  logic                  sck,
    input  logic                  rst_n,
    input  logic                  ws,
    input  logic                  sd,
    input  logic                  cfg_enable,
    input  logic                  cfg_tdm,
    input  logic [SLOT_CFG_W-1:0] cfg_slot_bits,
    input  logic [DEPTH_W-1:0]    cfg_depth,
    input  logic [CHN_W-1:0]      cfg_channels,
    input  logic                  cfg_inv_ws,
    input  logic                  cfg_inv_sck,
    output logic                  out_valid,
    output logic [SAMPLE_W-1:0]   out_sample,
    output logic [CH_W-1:0]       out_channel
);
    logic clk_int;
    logic ws_rise, ws_fall;
    logic clr, shift_en, emit;

    assign clk_int = sck ^ cfg_inv_sck;

    aud_cap_front u_front (
        .clk     (clk_int),
        .rst_n   (rst_n),
        .ws_raw  (ws),
        .inv_ws  (cfg_inv_ws),
        .ws_rise (ws_rise),
        .ws_fall (ws_fall)
    );

    aud_cap_ctrl #(
        .SLOT_MAX (SLOT_MAX),
        .CH_MAX   (CH_MAX),
        .SAMPLE_W (SAMPLE_W)
    ) u_ctrl (
        .clk         (clk_int),
        .rst_n       (rst_n),
        .enable      (cfg_enable),
        .tdm         (cfg_tdm),
        .slot_bits   (cfg_slot_bits),
        .depth       (cfg_depth),
        .channels    (cfg_channels),
        .ws_rise     (ws_rise),
        .ws_fall     (ws_fall),
        .clr         (clr),
        .shift_en    (shift_en),
        .emit        (emit),
        .out_valid   (out_valid),
        .out_channel (out_channel)
    );

    aud_cap_shift #(
        .SAMPLE_W (SAMPLE_W)
    ) u_shift (
        .clk        (clk_int),
        .rst_n      (rst_n),
        .sd         (sd),
        .clr        (clr),
        .shift_en   (shift_en),
        .emit       (emit),
        .out_sample (out_sample)
    );
endmodule

// File: rtl/aud_frame_cap_chk.sv
module aud_frame_cap_chk #(
    parameter  int CH_MAX   = 8,
    parameter  int SAMPLE_W = 32,
    localparam int CH_W     = $clog2(CH_MAX),
    localparam int CHN_W    = $clog2(CH_MAX + 1),
    localparam int DEPTH_W  = $clog2(SAMPLE_W + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_enable,
    input logic                cfg_tdm,
    input logic [DEPTH_W-1:0]  cfg_depth,
    input logic [CHN_W-1:0]    cfg_channels,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_sample,
    input logic [CH_W-1:0]     out_channel
);
    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_upper_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (int'(cfg_depth) < SAMPLE_W)) |-> ((out_sample >> cfg_depth) == '0));

    assert_tdm_channel_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_tdm) |-> (int'(out_channel) < int'(cfg_channels)));

    assert_stereo_channel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !cfg_tdm) |-> (int'(out_channel) <= 1));

    assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !out_valid);
endmodule

bind aud_frame_cap aud_frame_cap_chk #(
    .CH_MAX   (CH_MAX),
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk          (clk_int),
    .rst_n        (rst_n),
    .cfg_enable   (cfg_enable),
    .cfg_tdm      (cfg_tdm),
    .cfg_depth    (cfg_depth),
    .cfg_channels (cfg_channels),
    .out_valid    (out_valid),
    .out_sample   (out_sample),
    .out_channel  (out_channel)
);

// File: tb/aud_frame_cap_bench.sv
`timescale 1ns/1ps
module aud_frame_cap_bench;
    logic        sck = 1'b0;
    logic        rst_n = 1'b0;
    logic        ws = 1'b0;
    logic        sd = 1'b0;
    logic        cfg_enable = 1'b1;
    logic        cfg_tdm = 1'b0;
    logic [5:0]  cfg_slot_bits = 6'd32;
    logic [5:0]  cfg_depth = 6'd24;
    logic [3:0]  cfg_channels = 4'd8;
    logic        cfg_inv_ws = 1'b0;
    logic        cfg_inv_sck = 1'b0;
    logic        out_valid;
    logic [31:0] out_sample;
    logic [2:0]  out_channel;

    aud_frame_cap u_aud_frame_cap (
        .sck(sck), .rst_n(rst_n), .ws(ws), .sd(sd),
        .cfg_enable(cfg_enable), .cfg_tdm(cfg_tdm),
        .cfg_slot_bits(cfg_slot_bits), .cfg_depth(cfg_depth),
        .cfg_channels(cfg_channels), .cfg_inv_ws(cfg_inv_ws),
        .cfg_inv_sck(cfg_inv_sck), .out_valid(out_valid),
        .out_sample(out_sample), .out_channel(out_channel)
    );

    always #2.5 sck = ~sck;

    int checks = 0;
    int errors = 0;
    int cur_period = -1;

    logic ws_arr [0:599];
    logic sd_arr [0:599];
    logic en_arr [0:599];
    logic [31:0] exp_s [0:63];
    int          exp_c [0:63];
    int          exp_p [0:63];
    int          exp_n;

    logic [31:0] cap_s [0:255];
    int          cap_c [0:255];
    int          cap_p [0:255];
    int          cap_n = 0;
    int          cap_base;

    // capture monitor: samples shortly after the capturing edge
    always begin
        if (cfg_inv_sck) @(negedge sck); else @(posedge sck);
        #1;
        if (out_valid === 1'b1) begin
            if (cap_n < 256) begin
                cap_s[cap_n] = out_sample;
                cap_c[cap_n] = int'(out_channel);
                cap_p[cap_n] = cur_period;
            end
            cap_n = cap_n + 1;
        end
    end

    task automatic drive_edge;
        if (cfg_inv_sck) @(posedge sck); else @(negedge sck);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic start_reset;
        drive_edge();
        rst_n = 1'b0;
    endtask

    task automatic clear_stream(input logic ws0);
        for (int i = 0; i < 600; i++) begin
            ws_arr[i] = ws0;
            sd_arr[i] = 1'b0;
            en_arr[i] = 1'b1;
        end
        exp_n = 0;
    endtask

    task automatic set_ws(input int a, input int b, input logic lv);
        for (int i = a; i <= b; i++) ws_arr[i] = lv;
    endtask

    task automatic put_data(input int p, input logic [31:0] val, input int slot,
                            input int depth, input bit keep, input int ch);
        logic [31:0] m;
        for (int i = 0; i < slot; i++)
            sd_arr[p+i] = (i < depth) ? val[depth-1-i] : 1'b1;
        m = (depth >= 32) ? 32'hFFFF_FFFF : ((32'd1 << depth) - 32'd1);
        if (keep) begin
            exp_s[exp_n] = val & m;
            exp_c[exp_n] = ch;
            exp_p[exp_n] = p + slot - 1;
            exp_n = exp_n + 1;
        end
    endtask

    task automatic i2s_slot(input int p, input logic lv, input logic [31:0] val,
                            input int slot, input int depth, input bit keep);
        set_ws(p - 1, p + slot - 2, lv);
        put_data(p, val, slot, depth, keep, lv ? 1 : 0);
    endtask

    task automatic play(input int n, input string req);
        ws = ws_arr[0] ^ cfg_inv_ws;
        sd = 1'b0;
        cfg_enable = en_arr[0];
        cur_period = -1;
        repeat (3) drive_edge();
        cap_base = cap_n;
        rst_n = 1'b1;
        for (int j = 0; j < n; j++) begin
            drive_edge();
            ws = ws_arr[j] ^ cfg_inv_ws;
            sd = sd_arr[j];
            cfg_enable = en_arr[j];
            cur_period = j;
        end
        drive_edge();
        chk((cap_n - cap_base) == exp_n, req, "sample count", cap_n - cap_base, exp_n);
        for (int i = 0; i < exp_n; i++) begin
            if (cap_base + i < cap_n) begin
                chk(cap_s[cap_base+i] === exp_s[i], req, $sformatf("sample %0d value", i),
                    cap_s[cap_base+i], exp_s[i]);
                chk(cap_c[cap_base+i] == exp_c[i], req, $sformatf("sample %0d channel", i),
                    cap_c[cap_base+i], exp_c[i]);
                chk(cap_p[cap_base+i] == exp_p[i], req, $sformatf("sample %0d period", i),
                    cap_p[cap_base+i], exp_p[i]);
            end
        end
    endtask

    task automatic set_cfg(input logic tdm, input int slot, input int depth, input int ch,
                           input logic iws, input logic isck);
        cfg_tdm = tdm;
        cfg_slot_bits = 6'(slot);
        cfg_depth = 6'(depth);
        cfg_channels = 4'(ch);
        cfg_inv_ws = iws;
        cfg_inv_sck = isck;
    endtask

    // R1: reset values and no start from a level held since reset
    task automatic t_reset;
        start_reset();
        set_cfg(1'b0, 16, 16, 2, 1'b0, 1'b0);
        #20;
        chk(out_valid === 1'b0, "R1", "out_valid in reset", 32'(out_valid), 0);
        chk(out_sample === 32'd0, "R1", "out_sample in reset", out_sample, 0);
        clear_stream(1'b1);
        for (int i = 0; i < 60; i++) sd_arr[i] = i[0];
        play(60, "R1");
    endtask

    // R2 R3 R4: padded stereo, 24 bits in 32-clock slots
    task automatic t_i2s_padded;
        start_reset();
        set_cfg(1'b0, 32, 24, 2, 1'b0, 1'b0);
        clear_stream(1'b1);
        i2s_slot(4,   1'b0, 32'h00A5C3F1, 32, 24, 1'b1);
        i2s_slot(36,  1'b1, 32'h005A0F3C, 32, 24, 1'b1);
        i2s_slot(68,  1'b0, 32'h00123456, 32, 24, 1'b1);
        i2s_slot(100, 1'b1, 32'h00FEDCBA, 32, 24, 1'b1);
        play(140, "R2");
    endtask

    // R2 R3: unpadded stereo, 16 bits in 16-clock slots
    task automatic t_i2s_tight;
        start_reset();
        set_cfg(1'b0, 16, 16, 2, 1'b0, 1'b0);
        clear_stream(1'b1);
        i2s_slot(4,  1'b0, 32'h0000BEEF, 16, 16, 1'b1);
        i2s_slot(20, 1'b1, 32'h00001234, 16, 16, 1'b1);
        i2s_slot(36, 1'b0, 32'h00008001, 16, 16, 1'b1);
        i2s_slot(52, 1'b1, 32'h00007FFE, 16, 16, 1'b1);
        play(80, "R3");
    endtask

    // R5: eight padded TDM slots, wide marker pulse whose fall is ignored
    task automatic t_tdm8;
        start_reset();
        set_cfg(1'b1, 32, 24, 8, 1'b0, 1'b0);
        clear_stream(1'b0);
        set_ws(3, 10, 1'b1);
        for (int k = 0; k < 8; k++)
            put_data(4 + 32*k, (32'h00C0FFEE ^ (32'h00013579 * k)) & 32'h00FFFFFF,
                     32, 24, 1'b1, k);
        play(280, "R5");
    endtask

    // R5: six unpadded slots, one extra slot skipped, then a second frame
    task automatic t_tdm6;
        start_reset();
        set_cfg(1'b1, 24, 24, 6, 1'b0, 1'b0);
        clear_stream(1'b0);
        set_ws(3, 3, 1'b1);
        for (int k = 0; k < 6; k++)
            put_data(4 + 24*k, 32'h00100001 * (k + 3), 24, 24, 1'b1, k);
        put_data(4 + 24*6, 32'h00FFFFFF, 24, 24, 1'b0, 0);
        set_ws(171, 171, 1'b1);
        for (int k = 0; k < 6; k++)
            put_data(172 + 24*k, 32'h00ABCDEF ^ (32'h00000F0F * k), 24, 24, 1'b1, k);
        play(330, "R5");
    endtask

    // R6: word-select flips in the middle of the left slot
    task automatic t_resync;
        start_reset();
        set_cfg(1'b0, 32, 24, 2, 1'b0, 1'b0);
        clear_stream(1'b1);
        i2s_slot(4,  1'b0, 32'h00FFFFFF, 32, 24, 1'b0);
        i2s_slot(15, 1'b1, 32'h00C33C5A, 32, 24, 1'b1);
        i2s_slot(47, 1'b0, 32'h00654321, 32, 24, 1'b1);
        play(100, "R6");
    endtask

    // R7: inverted word-select swaps the physical levels
    task automatic t_inv_ws;
        start_reset();
        set_cfg(1'b0, 16, 16, 2, 1'b1, 1'b0);
        clear_stream(1'b1);
        i2s_slot(4,  1'b0, 32'h0000A001, 16, 16, 1'b1);
        i2s_slot(20, 1'b1, 32'h00005FF0, 16, 16, 1'b1);
        play(50, "R7");
    endtask

    // R8: capture on the falling bit-clock edge
    task automatic t_inv_sck;
        start_reset();
        set_cfg(1'b0, 32, 24, 2, 1'b0, 1'b1);
        clear_stream(1'b1);
        i2s_slot(4,  1'b0, 32'h00E1E2E3, 32, 24, 1'b1);
        i2s_slot(36, 1'b1, 32'h001F2F3F, 32, 24, 1'b1);
        play(80, "R8");
        cfg_inv_sck = 1'b0;
    endtask

    // R9: disabled frame produces nothing, enabled frame does, drop mid-slot discards
    task automatic t_enable;
        start_reset();
        set_cfg(1'b0, 16, 16, 2, 1'b0, 1'b0);
        clear_stream(1'b1);
        for (int i = 0; i < 40; i++) en_arr[i] = 1'b0;
        i2s_slot(4,  1'b0, 32'h00001111, 16, 16, 1'b0);
        i2s_slot(20, 1'b1, 32'h00002222, 16, 16, 1'b0);
        i2s_slot(50, 1'b0, 32'h00003333, 16, 16, 1'b1);
        i2s_slot(66, 1'b1, 32'h00004444, 16, 16, 1'b1);
        i2s_slot(82, 1'b0, 32'h00005555, 16, 16, 1'b0);
        for (int i = 90; i < 110; i++) en_arr[i] = 1'b0;
        play(110, "R9");
    endtask

    // R10: full 32-bit samples in TDM
    task automatic t_depth32;
        start_reset();
        set_cfg(1'b1, 32, 32, 2, 1'b0, 1'b0);
        clear_stream(1'b0);
        set_ws(3, 3, 1'b1);
        put_data(4,  32'h80000001, 32, 32, 1'b1, 0);
        put_data(36, 32'hDEADBEEF, 32, 32, 1'b1, 1);
        play(80, "R10");
    endtask

    initial begin
        #200000;
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_i2s_padded();
        t_i2s_tight();
        t_tdm8();
        t_tdm6();
        t_resync();
        t_inv_ws();
        t_inv_sck();
        t_enable();
        t_depth32();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule